// File: doc/BRIEF.md
# Flash Program and Erase Command Controller

This block sits between a host register bus and a flash array. Software loads a target address, four 32-bit data words and a clock-divider value. It then writes a control word that carries a start request, a lock key and an erase qualifier. When the key and qualifier are correct, the controller launches one command to the flash array. The command is a word write, a page erase or a mass erase. The controller then times the operation in units of a divided timing tick and waits for the array to drop its busy line. At the end it clears the start request and raises a completion flag.

A launch with the wrong key, a missing qualifier or more than one start bit starts nothing and raises an access-fault flag. An error reported by the array at completion also raises that flag. Each flag has an enable, and the enabled flags are ORed onto one interrupt line. While an operation is pending, the registers that feed the array are frozen against host writes.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, and `irq` and `fl_start` are low.
- R2: The register offsets are as follows, and all of them read back what was written:
  - address at 0x00 (32 bits);
  - divider at 0x04 (low 8 bits);
  - control at 0x08;
  - interrupt at 0x24;
  - data words 0 to 3 at 0x30, 0x34, 0x38 and 0x3C.
  
  An unmapped offset reads 0. The control word reads back as follows:
  - bits 31:28: key;
  - bit 24: pending;
  - bits 15:8: qualifier;
  - bits 2:0: start bits.
- R3: A launch requires key value 0x2 in control bits 31:28 and exactly one start bit. Bit 0 is a word write and needs no qualifier. Bit 1 is a mass erase and needs qualifier 0xAA in bits 15:8. Bit 2 is a page erase and needs qualifier 0x55. A launch sets pending on the next edge, pulses `fl_start` for one cycle and drives `fl_op` (1 = write, 2 = mass, 3 = page), `fl_addr` and `fl_data` (word i at bits 32i+31:32i).
- R4: A control write with any start bit set that breaks R3 sets the fault flag (interrupt bit 1). It starts nothing and leaves the start bits reading 0.
- R5: With divider value D (0 is treated as 1) and an operation length of N ticks, pending falls N*D+1 cycles after the edge that captured the control write, provided `fl_busy` is low. The default lengths are 2 ticks for a write, 6 for a mass erase and 4 for a page erase.
- R6: Completion has three effects on the same edge: the start bits clear, pending falls and the done flag (interrupt bit 0) sets.
- R7: Completion waits for `fl_busy` to be low. Pending falls one edge after the first cycle in which the tick count has elapsed and `fl_busy` is low.
- R8: If `fl_error` is high in the completion cycle, the fault flag sets together with the done flag.
- R9: While pending is high, writes to the address, data and control registers have no effect, and they raise no fault.
- R10: Writing 0 to interrupt bit 0 or bit 1 clears that flag, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R11: `irq` is high exactly when done is set with its enable (bit 8) high, or fault is set with its enable (bit 9) high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 8 | Host byte offset for reads and writes |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| fl_start | output | 1 | One-cycle command pulse to the array |
| fl_op | output | 2 | Command code: 1 write, 2 mass erase, 3 page erase |
| fl_addr | output | 32 | Target address |
| fl_data | output | 128 | Four write-data words |
| fl_busy | input | 1 | Array busy |
| fl_error | input | 1 | Array error, sampled at completion |
| irq | output | 1 | Combined interrupt |

## Verification
The completion of an operation and a host write to the interrupt register can land on the same clock edge. In that case the flag set by hardware and the flag clear requested by software conflict. The bench times a word write with divider 1, so completion falls exactly three edges after the launch. It places an interrupt-register write of zero on that edge while an old fault flag is still set. The expected result is done set (the set wins) and the old fault cleared (no set competes for it).

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_MASS  = 2'd2,
    OP_PAGE  = 2'd3
  } flc_op_e;

  localparam logic [7:0] OFS_ADDR = 8'h00;
  localparam logic [7:0] OFS_DIV  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_INT  = 8'h24;
  localparam logic [7:0] OFS_DATA = 8'h30;

  localparam logic [3:0] KEY_OPEN  = 4'h2;
  localparam logic [7:0] QUAL_PAGE = 8'h55;
  localparam logic [7:0] QUAL_MASS = 8'hAA;
endpackage

// File: rtl/flc_tick_div.sv
module flc_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;
  logic             cnt_en;

  always_comb begin
    lim    = (div == '0) ? '0 : div - 1'b1;
    tick   = run && (cnt_q >= lim);
    cnt_d  = (!run || tick) ? '0 : cnt_q + 1'b1;
    cnt_en = run || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/flc_op_timer.sv
module flc_op_timer
  import flc_pkg::*;
#(
  parameter int WR_TICKS   = 2,
  parameter int MASS_TICKS = 6,
  parameter int PAGE_TICKS = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    tick,
  input  flc_op_e op,
  input  logic    fl_busy,
  output logic    finish
);
  localparam int MAX_AB = (WR_TICKS > MASS_TICKS) ? WR_TICKS : MASS_TICKS;
  localparam int MAXT   = (MAX_AB > PAGE_TICKS) ? MAX_AB : PAGE_TICKS;
  localparam int CW     = $clog2(MAXT + 1);

  logic [CW-1:0] tcnt_q, tcnt_d, target;
  logic          elapsed_q, elapsed_d, clr, upd;

  always_comb begin
    case (op)
      OP_WRITE: target = CW'(WR_TICKS);
      OP_MASS:  target = CW'(MASS_TICKS);
      OP_PAGE:  target = CW'(PAGE_TICKS);
      default:  target = CW'(1);
    endcase
    finish    = run && elapsed_q && !fl_busy;
    clr       = !run || finish;
    upd       = clr || (tick && !elapsed_q);
    tcnt_d    = clr ? '0 : tcnt_q + 1'b1;
    elapsed_d = clr ? 1'b0 : ((tcnt_q + 1'b1) == target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q    <= '0;
      elapsed_q <= 1'b0;
    end else if (upd) begin
      tcnt_q    <= tcnt_d;
      elapsed_q <= elapsed_d;
    end
  end
endmodule

// File: rtl/flc_launch_chk.sv
module flc_launch_chk
  import flc_pkg::*;
(
  input  logic [2:0] start,
  input  logic [3:0] key,
  input  logic [7:0] qual,
  output logic       ok,
  output logic       bad,
  output flc_op_e    op
);
  logic one_hot, qual_ok;

  always_comb begin
    one_hot = (start == 3'b001) || (start == 3'b010) || (start == 3'b100);
    op      = start[0] ? OP_WRITE : (start[1] ? OP_MASS : OP_PAGE);
    case (op)
      OP_MASS: qual_ok = (qual == QUAL_MASS);
      OP_PAGE: qual_ok = (qual == QUAL_PAGE);
      default: qual_ok = 1'b1;
    endcase
    ok  = one_hot && (key == KEY_OPEN) && qual_ok;
    bad = (start != 3'b000) && !ok;
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flc_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int NWORDS     = 4,
  parameter int WR_TICKS   = 2,
  parameter int MASS_TICKS = 6,
  parameter int PAGE_TICKS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [7:0]             bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   fl_start,
  output logic [1:0]             fl_op,
  output logic [31:0]            fl_addr,
  output logic [NWORDS*32-1:0]   fl_data,
  input  logic                   fl_busy,
  input  logic                   fl_error,
  output logic                   irq
);
  localparam int DW = NWORDS * 32;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [31:0]      addr_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       start_q, start_d;
  logic [3:0]       key_q, key_d;
  logic [7:0]       qual_q, qual_d;
  logic             pend_q, pend_d;
  flc_op_e          op_q, op_d;
  logic             flstart_q;
  logic             done_q, done_d, fault_q, fault_d;
  logic             done_en_q, fault_en_q;
  logic [31:0]      data_q [NWORDS];

  logic wr_addr, wr_div, wr_ctrl, wr_int, ctrl_take;
  logic chk_ok, chk_bad, launch, bad_launch, tick, finish;
  flc_op_e chk_op;

  always_comb begin
    wr_addr    = bus_we && (bus_addr == OFS_ADDR) && !pend_q;
    wr_div     = bus_we && (bus_addr == OFS_DIV);
    wr_ctrl    = bus_we && (bus_addr == OFS_CTRL);
    wr_int     = bus_we && (bus_addr == OFS_INT);
    ctrl_take  = wr_ctrl && !pend_q;
    launch     = ctrl_take && chk_ok;
    bad_launch = ctrl_take && chk_bad;
  end

  flc_launch_chk i_launch_chk (
    .start (bus_wdata[2:0]),
    .key   (bus_wdata[31:28]),
    .qual  (bus_wdata[15:8]),
    .ok    (chk_ok),
    .bad   (chk_bad),
    .op    (chk_op)
  );

  flc_tick_div #(.DIV_W(DIV_W)) i_tick_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (pend_q),
    .div   (div_q),
    .tick  (tick)
  );

  flc_op_timer #(
    .WR_TICKS   (WR_TICKS),
    .MASS_TICKS (MASS_TICKS),
    .PAGE_TICKS (PAGE_TICKS)
  ) i_op_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (pend_q),
    .tick    (tick),
    .op      (op_q),
    .fl_busy (fl_busy),
    .finish  (finish)
  );

  // next state
  always_comb begin
    key_d   = ctrl_take ? bus_wdata[31:28] : key_q;
    qual_d  = ctrl_take ? bus_wdata[15:8]  : qual_q;
    start_d = start_q;
    if (ctrl_take) start_d = chk_ok ? bus_wdata[2:0] : 3'b000;
    if (finish)    start_d = 3'b000;
    pend_d  = launch ? 1'b1 : (finish ? 1'b0 : pend_q);
    op_d    = launch ? chk_op : op_q;
    done_d  = done_q;
    fault_d = fault_q;
    if (wr_int && !bus_wdata[0]) done_d  = 1'b0;
    if (wr_int && !bus_wdata[1]) fault_d = 1'b0;
    if (finish)                                done_d  = 1'b1;
    if (bad_launch || (finish && fl_error))    fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q     <= '0;
      div_q      <= '0;
      start_q    <= '0;
      key_q      <= '0;
      qual_q     <= '0;
      pend_q     <= 1'b0;
      op_q       <= OP_NONE;
      flstart_q  <= 1'b0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      done_en_q  <= 1'b0;
      fault_en_q <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= bus_wdata;
      if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
      if (wr_int) begin
        done_en_q  <= bus_wdata[8];
        fault_en_q <= bus_wdata[9];
      end
      start_q   <= start_d;
      key_q     <= key_d;
      qual_q    <= qual_d;
      pend_q    <= pend_d;
      op_q      <= op_d;
      flstart_q <= launch;
      done_q    <= done_d;
      fault_q   <= fault_d;
    end
  end

  // data words, one register per word
  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    logic wr_word;
    assign wr_word = bus_we && !pend_q && (bus_addr == OFS_DATA + 8'(gi * 4));
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  data_q[gi] <= '0;
      else if (wr_word) data_q[gi] <= bus_wdata;
    end
    assign fl_data[gi*32 +: 32] = data_q[gi];
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_ADDR: bus_rdata = addr_q;
      OFS_DIV:  bus_rdata = 32'(div_q);
      OFS_CTRL: bus_rdata = {key_q, 3'b000, pend_q, 8'h00, qual_q, 5'b00000, start_q};
      OFS_INT:  bus_rdata = {22'd0, fault_en_q, done_en_q, 6'd0, fault_q, done_q};
      default: begin
        for (int i = 0; i < NWORDS; i++)
          if (bus_addr == OFS_DATA + 8'(i * 4)) bus_rdata = data_q[i];
      end
    endcase
  end

  assign fl_start = flstart_q;
  assign fl_op    = op_q;
  assign fl_addr  = addr_q;
  assign irq      = (done_q && done_en_q) || (fault_q && fault_en_q);

  logic unused_dw;
  assign unused_dw = (DW == 0);
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fl_start,
  input logic          fl_busy,
  input logic [1:0]    fl_op,
  input logic [31:0]   fl_addr,
  input logic [DW-1:0] fl_data,
  input logic          irq,
  input logic          pend,
  input logic          done_flag,
  input logic          fault_flag
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !fl_start);                                              // R3
  AST_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> pend);                                                   // R3
  AST_PEND_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> done_flag);                                           // R6
  AST_FINISH_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> !$past(fl_busy));                                     // R7
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |-> ($stable(fl_addr) && $stable(fl_data) && $stable(fl_op))); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_flag || fault_flag));                                   // R11
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.DW(NWORDS * 32)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .fl_start   (fl_start),
  .fl_busy    (fl_busy),
  .fl_op      (fl_op),
  .fl_addr    (fl_addr),
  .fl_data    (fl_data),
  .irq        (irq),
  .pend       (pend_q),
  .done_flag  (done_q),
  .fault_flag (fault_q)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_addr = 8'h00;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         fl_start;
  logic [1:0]   fl_op;
  logic [31:0]  fl_addr;
  logic [127:0] fl_data;
  logic         fl_busy;
  logic         fl_error = 1'b0;
  logic         irq;

  int checks = 0;
  int failures = 0;
  int busy_len = 0;
  int busy_cnt = 0;
  int n_starts = 0;
  logic [1:0]   cap_op;
  logic [31:0]  cap_addr;
  logic [127:0] cap_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_start(fl_start),
    .fl_op(fl_op), .fl_addr(fl_addr), .fl_data(fl_data),
    .fl_busy(fl_busy), .fl_error(fl_error), .irq(irq)
  );

  // behavioural flash array
  always @(posedge clk) begin
    if (fl_start) begin
      busy_cnt <= busy_len;
      n_starts <= n_starts + 1;
      cap_op   <= fl_op;
      cap_addr <= fl_addr;
      cap_data <= fl_data;
    end else if (busy_cnt != 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end
  assign fl_busy = (busy_cnt != 0);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // cycles from the capture edge of the last write until pending reads 0
  task automatic wait_idle(output int k);
    bus_addr = 8'h08;
    k = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      k++;
      #1;
      if (!bus_rdata[24]) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_read(8'h00, v); check("R1 addr", v, 0);
    bus_read(8'h04, v); check("R1 div", v, 0);
    bus_read(8'h08, v); check("R1 ctrl", v, 0);
    bus_read(8'h24, v); check("R1 int", v, 0);
    bus_read(8'h3C, v); check("R1 data3", v, 0);
    check("R1 irq", irq, 0);
    check("R1 fl_start", fl_start, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    bus_write(8'h00, 32'h1234_5678);
    bus_write(8'h04, 32'h0000_0003);
    for (int i = 0; i < 4; i++) bus_write(8'h30 + 8'(i * 4), 32'hA0B0_0000 + 32'(i));
    bus_write(8'h08, 32'h2000_5500);
    bus_read(8'h00, v); check("R2 addr", v, 32'h1234_5678);
    bus_read(8'h04, v); check("R2 div", v, 32'h3);
    bus_read(8'h08, v); check("R2 ctrl", v, 32'h2000_5500);
    for (int i = 0; i < 4; i++) begin
      bus_read(8'h30 + 8'(i * 4), v); check("R2 data", v, 32'hA0B0_0000 + 32'(i));
    end
    bus_read(8'h10, v); check("R2 unmapped", v, 0);
  endtask

  task automatic t_write_op;
    int k, s0;
    logic [31:0] v;
    s0 = n_starts;
    bus_write(8'h08, 32'h2000_0001);
    wait_idle(k);
    check("R5 write cycles D=3", 32'(k), 32'(2 * 3 + 1));
    check("R3 one start pulse", 32'(n_starts - s0), 1);
    check("R3 op write", cap_op, 2'd1);
    check("R3 addr", cap_addr, 32'h1234_5678);
    check("R3 data", cap_data, {32'hA0B0_0003, 32'hA0B0_0002, 32'hA0B0_0001, 32'hA0B0_0000});
    bus_read(8'h08, v); check("R6 start bits cleared", v, 32'h2000_0000);
    bus_read(8'h24, v); check("R6 done set", v, 32'h1);
  endtask

  task automatic t_page_mass;
    int k;
    bus_write(8'h24, 32'h0);
    bus_write(8'h04, 32'h1);
    bus_write(8'h08, 32'h2000_5504);
    wait_idle(k);
    check("R5 page cycles D=1", 32'(k), 32'(4 + 1));
    check("R3 op page", cap_op, 2'd3);
    bus_write(8'h04, 32'h0);
    bus_write(8'h08, 32'h2000_AA02);
    wait_idle(k);
    check("R5 mass cycles D=0", 32'(k), 32'(6 + 1));
    check("R3 op mass", cap_op, 2'd2);
  endtask

  task automatic t_bad;
    logic [31:0] v;
    int s0;
    s0 = n_starts;
    bus_write(8'h24, 32'h0);
    bus_write(8'h08, 32'h3000_0001);
    bus_read(8'h24, v); check("R4 locked key fault", v, 32'h2);
    bus_read(8'h08, v); check("R4 no start bits", v, 32'h3000_0000);
    bus_write(8'h24, 32'h0);
    bus_write(8'h08, 32'h2000_AA04);
    bus_read(8'h24, v); check("R4 wrong qualifier fault", v, 32'h2);
    bus_write(8'h24, 32'h0);
    bus_write(8'h08, 32'h2000_0003);
    bus_read(8'h24, v); check("R4 two start bits fault", v, 32'h2);
    repeat (12) @(negedge clk);
    check("R4 nothing started", 32'(n_starts - s0), 0);
    bus_write(8'h24, 32'h0);
  endtask

  task automatic t_clear_irq;
    logic [31:0] v;
    int k;
    bus_write(8'h08, 32'h2000_0001);
    wait_idle(k);
    bus_write(8'h08, 32'h3000_0001);
    bus_write(8'h24, 32'h0000_0003);
    bus_read(8'h24, v); check("R10 write 1 keeps flags", v, 32'h3);
    check("R11 irq off without enable", irq, 0);
    bus_write(8'h24, 32'h0000_0103);
    #1 check("R11 irq done enabled", irq, 1);
    bus_write(8'h24, 32'h0000_0202);
    bus_read(8'h24, v); check("R10 clear done only", v, 32'h202);
    check("R11 irq fault enabled", irq, 1);
    bus_write(8'h24, 32'h0000_0201);
    bus_read(8'h24, v); check("R10 clear fault", v, 32'h200);
    check("R11 irq off no flag", irq, 0);
    bus_write(8'h24, 32'h0);
  endtask

  task automatic t_frozen;
    logic [31:0] v;
    int k;
    bus_write(8'h04, 32'd10);
    bus_write(8'h08, 32'h2000_0001);
    bus_write(8'h00, 32'hDEAD_0000);
    bus_write(8'h30, 32'hDEAD_0001);
    bus_write(8'h08, 32'h3000_0004);
    bus_read(8'h00, v); check("R9 addr frozen", v, 32'h1234_5678);
    bus_read(8'h30, v); check("R9 data frozen", v, 32'hA0B0_0000);
    bus_read(8'h08, v); check("R9 ctrl frozen", v, 32'h2100_0001);
    bus_read(8'h24, v); check("R9 no fault", v, 32'h0);
    wait_idle(k);
    bus_write(8'h24, 32'h0);
  endtask

  task automatic t_busy_error;
    logic [31:0] v;
    int k;
    bus_write(8'h04, 32'h1);
    busy_len = 20;
    bus_write(8'h08, 32'h2000_0001);
    wait_idle(k);
    check("R7 waits for busy", 32'(k), 32'(20 + 2));
    busy_len = 0;
    bus_write(8'h24, 32'h0);
    fl_error = 1'b1;
    bus_write(8'h08, 32'h2000_0001);
    wait_idle(k);
    fl_error = 1'b0;
    bus_read(8'h24, v); check("R8 error sets fault and done", v, 32'h3);
    bus_write(8'h24, 32'h0);
  endtask

  task automatic t_coincide;
    logic [31:0] v;
    bus_write(8'h04, 32'h1);
    bus_write(8'h08, 32'h3000_0001);   // leaves fault set
    bus_write(8'h08, 32'h2000_0001);   // launch captured at edge E0
    @(negedge clk);                    // next write captured at E0+3 = completion
    bus_write(8'h24, 32'h0);
    bus_read(8'h24, v); check("R10 set wins over clear", v, 32'h1);
    bus_read(8'h08, v); check("R6 idle after coincidence", v[24], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regmap;
    t_write_op;
    t_page_mass;
    t_bad;
    t_clear_irq;
    t_frozen;
    t_busy_error;
    t_coincide;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule